// File: doc/BRIEF.md
# Cascadable Octal Up/Down Counter

This block is an 8-bit synchronous counter that can do one of three things on each rising clock edge: take a parallel value, step up by one, or step down by one. Either counting step falls back to holding its value when the active-low chain input is deasserted. Three control inputs pick the operation: a load strobe (active low), a direction select and the chain input. The register value reaches the pins through a tri-state port. An active-low output enable controls that port and has no effect on the counting.

A terminal-count flag, also active low, is asserted when the register sits at the last value for the current direction. That is all-ones when counting up and all-zeros when counting down. The flag depends only on the register and the direction input, with no clock stage in between. To build a wider counter, connect each stage's chain input to the flag of the stage below it. Tie the lowest stage's chain input low and share the direction input across all stages.

A synchronous, active-high reset clears the register to zero.

Top module: `updown_octal_counter`

## Requirements
- R1: While rst is high at a rising clock edge, the register becomes 0x00.
- R2: With load_n low, the next rising edge copies din into the register whatever dir_down and cin_n are.
- R3: With load_n high, dir_down low (0 = up) and cin_n low, each rising edge adds one to the register, and 0xFF wraps to 0x00.
- R4: With load_n high, dir_down high (1 = down) and cin_n low, each rising edge subtracts one from the register, and 0x00 wraps to 0xFF.
- R5: With load_n high and cin_n high, the register keeps its value in both directions.
- R6: cout_n is low exactly when dir_down is 0 and the register is 0xFF, or when dir_down is 1 and the register is 0x00. It follows a change of dir_down with no clock edge.
- R7: q carries the register value while oe_n is low and is high-impedance on all bits while oe_n is high.
- R8: With oe_n high, loading, counting and holding proceed unchanged, and re-enabling the port shows the resulting value.
- R9: Two instances chained through cout_n to cin_n count as one 16-bit counter in both directions, with the carry and the borrow passing between stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Parallel load select, active low |
| dir_down | input | 1 | Count direction: 0 up, 1 down |
| cin_n | input | 1 | Carry/borrow in, active low; enables a count step |
| din | input | 8 | Parallel load value |
| oe_n | input | 1 | Output enable for q, active low |
| q | output | 8 | Tri-state register output |
| cout_n | output | 1 | Carry/borrow out, active low, at terminal count |

## Verification
The bound checker tests these properties on every clock: each register update against the operation chosen one cycle earlier (load, step up, step down, hold), the flag against the register and the direction, and the enabled port against the register. The bench scenarios cover what the checker cannot see: the wrap at both ends of the range, the high-impedance port (a pull-up on the bench's bus shows it as all-ones), counting that goes on while the port is disabled, and a two-stage chain that must carry from 0x00FF to 0x0100 and borrow back.

// File: rtl/updown_octal_counter_pkg.sv
package updown_octal_counter_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_LOAD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } ctr_op_e;

    typedef struct packed {
        logic load_n;
        logic dir_down;
        logic cin_n;
    } ctr_ctl_t;

    // Load has priority; a step needs the active-low chain input.
    function automatic ctr_op_e decode_op(input ctr_ctl_t ctl);
        if (!ctl.load_n)     return OP_LOAD;
        else if (ctl.cin_n)  return OP_HOLD;
        else if (ctl.dir_down) return OP_DOWN;
        else                 return OP_UP;
    endfunction

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
    import updown_octal_counter_pkg::*;
(
    input  ctr_ctl_t ctl,
    output ctr_op_e  op
);
    always_comb op = decode_op(ctl);
endmodule

// File: rtl/ctr_next_value.sv
module ctr_next_value
    import updown_octal_counter_pkg::*;
#(
    parameter int W = 8
) (
    input  ctr_op_e        op,
    input  logic [W-1:0]   cur,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (op)
            OP_LOAD: nxt = din;
            OP_UP:   nxt = cur + ONE;
            OP_DOWN: nxt = cur - ONE;
            default: nxt = cur;
        endcase
    end
endmodule

// File: rtl/ctr_term_detect.sv
module ctr_term_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] cur,
    input  logic         dir_down,
    output logic         cout_n
);
    localparam logic [W-1:0] TOP = {W{1'b1}};
    localparam logic [W-1:0] BOT = '0;

    logic at_top, at_bot;
    always_comb begin
        at_top = (cur == TOP);
        at_bot = (cur == BOT);
        cout_n = dir_down ? !at_bot : !at_top;
    end
endmodule

// File: rtl/ctr_tristate_drv.sv
module ctr_tristate_drv #(
    parameter int W = 8
) (
    input  logic [W-1:0] val,
    input  logic         oe_n,
    output tri   [W-1:0] pad
);
    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            assign pad[i] = oe_n ? 1'bz : val[i];
        end
    endgenerate
endmodule

// File: rtl/updown_octal_counter.sv
module updown_octal_counter
    import updown_octal_counter_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         dir_down,
    input  logic         cin_n,
    input  logic [W-1:0] din,
    input  logic         oe_n,
    output tri   [W-1:0] q,
    output logic         cout_n
);
    ctr_ctl_t     ctl;
    ctr_op_e      op;
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;

    assign ctl = '{load_n: load_n, dir_down: dir_down, cin_n: cin_n};

    ctr_op_decode u_dec (
        .ctl (ctl),
        .op  (op)
    );

    ctr_next_value #(.W(W)) u_nxt (
        .op  (op),
        .cur (cnt_q),
        .din (din),
        .nxt (cnt_d)
    );

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    ctr_term_detect #(.W(W)) u_term (
        .cur      (cnt_q),
        .dir_down (dir_down),
        .cout_n   (cout_n)
    );

    ctr_tristate_drv #(.W(W)) u_drv (
        .val  (cnt_q),
        .oe_n (oe_n),
        .pad  (q)
    );
endmodule

// File: rtl/updown_octal_counter_chk.sv
module updown_octal_counter_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic         dir_down,
    input logic         cin_n,
    input logic [W-1:0] din,
    input logic         oe_n,
    input logic [W-1:0] q,
    input logic         cout_n,
    input logic [W-1:0] cnt_q
);
    localparam logic [W-1:0] ONE = W'(1);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (cnt_q == '0));

    a_r2_load_takes_din: assert property (@(posedge clk) disable iff (rst)
        !load_n |=> (cnt_q == $past(din)));

    a_r3_step_up: assert property (@(posedge clk) disable iff (rst)
        (load_n && !dir_down && !cin_n) |=> (cnt_q == $past(cnt_q) + ONE));

    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (load_n && dir_down && !cin_n) |=> (cnt_q == $past(cnt_q) - ONE));

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (load_n && cin_n) |=> $stable(cnt_q));

    a_r6_terminal_flag: assert property (@(posedge clk) disable iff (rst)
        !cout_n |-> (dir_down ? (cnt_q == '0) : (&cnt_q)));

    a_r7_port_follows: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (q == cnt_q));
endmodule

bind updown_octal_counter updown_octal_counter_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .load_n   (load_n),
    .dir_down (dir_down),
    .cin_n    (cin_n),
    .din      (din),
    .oe_n     (oe_n),
    .q        (q),
    .cout_n   (cout_n),
    .cnt_q    (cnt_q)
);

// File: tb/updown_octal_counter_tb_top.sv
`timescale 1ns/1ps
module updown_octal_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_n, dir_down, cin_n, oe_n;
    logic [7:0] din;
    wire  [7:0] q_bus;
    logic       cout_n;

    // cascade pair
    logic       c_load_n;
    logic [7:0] c_din_lo, c_din_hi;
    wire  [7:0] c_q_lo, c_q_hi;
    logic       c_cout_lo, c_cout_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pullup pu_bus (q_bus);

    updown_octal_counter dut_i (
        .clk(clk), .rst(rst), .load_n(load_n), .dir_down(dir_down),
        .cin_n(cin_n), .din(din), .oe_n(oe_n), .q(q_bus), .cout_n(cout_n)
    );

    updown_octal_counter lo_i (
        .clk(clk), .rst(rst), .load_n(c_load_n), .dir_down(dir_down),
        .cin_n(1'b0), .din(c_din_lo), .oe_n(1'b0), .q(c_q_lo), .cout_n(c_cout_lo)
    );

    updown_octal_counter hi_i (
        .clk(clk), .rst(rst), .load_n(c_load_n), .dir_down(dir_down),
        .cin_n(c_cout_lo), .din(c_din_hi), .oe_n(1'b0), .q(c_q_hi), .cout_n(c_cout_hi)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [7:0] v);
        load_n = 1'b0; din = v;
        step();
        load_n = 1'b1;
    endtask

    task automatic t_reset();
        rst = 1'b1; load_n = 1'b1; dir_down = 1'b0; cin_n = 1'b1; din = 8'h00;
        oe_n = 1'b0; c_load_n = 1'b1; c_din_lo = 8'h00; c_din_hi = 8'h00;
        step(); step();
        rst = 1'b0;
        check("R1 reset value", {8'h00, q_bus}, 16'h0000);
        check("R1 cascade reset", {c_q_hi, c_q_lo}, 16'h0000);
    endtask

    task automatic t_load();
        // dir and cin in odd states must not matter
        dir_down = 1'b1; cin_n = 1'b0;
        do_load(8'hA5);
        check("R2 load with down/cin low", {8'h00, q_bus}, 16'h00A5);
        dir_down = 1'b0; cin_n = 1'b1;
        do_load(8'h5A);
        check("R2 load with up/cin high", {8'h00, q_bus}, 16'h005A);
    endtask

    task automatic t_up();
        dir_down = 1'b0; cin_n = 1'b1;
        do_load(8'h10);
        cin_n = 1'b0;
        step(); step(); step();
        check("R3 count up x3", {8'h00, q_bus}, 16'h0013);
        cin_n = 1'b1;
        do_load(8'hFE);
        cin_n = 1'b0;
        step();
        check("R3 up to FF", {8'h00, q_bus}, 16'h00FF);
        step();
        check("R3 wrap FF to 00", {8'h00, q_bus}, 16'h0000);
        cin_n = 1'b1;
    endtask

    task automatic t_down();
        dir_down = 1'b1; cin_n = 1'b1;
        do_load(8'h02);
        cin_n = 1'b0;
        step(); step();
        check("R4 down to 00", {8'h00, q_bus}, 16'h0000);
        step();
        check("R4 wrap 00 to FF", {8'h00, q_bus}, 16'h00FF);
        step();
        check("R4 down FE", {8'h00, q_bus}, 16'h00FE);
        cin_n = 1'b1;
    endtask

    task automatic t_hold();
        cin_n = 1'b1;
        do_load(8'h77);
        dir_down = 1'b0;
        step(); step();
        check("R5 hold up-mode", {8'h00, q_bus}, 16'h0077);
        dir_down = 1'b1;
        step(); step();
        check("R5 hold down-mode", {8'h00, q_bus}, 16'h0077);
    endtask

    task automatic t_flag();
        cin_n = 1'b1;
        do_load(8'hFF);
        dir_down = 1'b0; #1;
        check("R6 up at FF low", {15'd0, cout_n}, 16'd0);
        dir_down = 1'b1; #1;
        check("R6 down at FF high", {15'd0, cout_n}, 16'd1);
        step();
        do_load(8'h00);
        dir_down = 1'b1; #1;
        check("R6 down at 00 low", {15'd0, cout_n}, 16'd0);
        dir_down = 1'b0; #1;
        check("R6 up at 00 high", {15'd0, cout_n}, 16'd1);
        step();
        do_load(8'h80);
        #1;
        check("R6 mid value high", {15'd0, cout_n}, 16'd1);
    endtask

    task automatic t_oe();
        oe_n = 1'b0; cin_n = 1'b1; dir_down = 1'b0;
        do_load(8'h3C);
        check("R7 enabled drives", {8'h00, q_bus}, 16'h003C);
        oe_n = 1'b1; #1;
        check("R7 disabled is Z (pulled up)", {8'h00, q_bus}, 16'h00FF);
        cin_n = 1'b0;
        step(); step();
        cin_n = 1'b1;
        oe_n = 1'b0; #1;
        check("R8 counted while disabled", {8'h00, q_bus}, 16'h003E);
        oe_n = 1'b1;
        do_load(8'h91);
        oe_n = 1'b0; #1;
        check("R8 loaded while disabled", {8'h00, q_bus}, 16'h0091);
    endtask

    task automatic t_cascade();
        dir_down = 1'b0;
        c_load_n = 1'b0; c_din_hi = 8'h00; c_din_lo = 8'hFE;
        step();
        c_load_n = 1'b1;
        check("R9 cascade load", {c_q_hi, c_q_lo}, 16'h00FE);
        step(); step();
        check("R9 carry into upper stage", {c_q_hi, c_q_lo}, 16'h0100);
        step();
        check("R9 upper stage holds", {c_q_hi, c_q_lo}, 16'h0101);
        dir_down = 1'b1;
        step(); step();
        check("R9 borrow from upper stage", {c_q_hi, c_q_lo}, 16'h00FF);
        c_load_n = 1'b0; c_din_hi = 8'hFF; c_din_lo = 8'hFF;
        dir_down = 1'b0;
        step();
        c_load_n = 1'b1;
        step();
        check("R9 16-bit wrap", {c_q_hi, c_q_lo}, 16'h0000);
    endtask

    initial begin
        t_reset();
        t_load();
        t_up();
        t_down();
        t_hold();
        t_flag();
        t_oe();
        t_cascade();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule